// File: doc/BRIEF.md
# Host Mailbox Port

This block connects an external host processor to an on-chip core through a small bank of shared mailbox registers. The host side is an asynchronous 8-bit parallel bus. It has a chip select, two strobe pins, an address latch enable, a 3-bit address and separate data-in and data-out pins. Two static strap inputs choose the bus style. One strap picks between separate active-low read and write strobes and a single read/write select paired with a data strobe. The other strap picks between addressing from the 3-bit address pins and a multiplexed scheme, in which the address travels on the low data bits while the latch enable is high.

The core side is a synchronous register bus with a select, a write enable, a 4-bit address and 16-bit data. The block records, for each data register, whether the host has written it and whether the host has completed a read of it. From these flags it raises two masked interrupt lines. It also offers a software reset bit that either side can set. Setting the bit produces a reset output pulse of fixed length. Host control pins pass through a two-flop synchronizer, and each access takes effect on the detected strobe edge inside the core clock domain.

Core register map: 0–5 are the data registers. 6 is the write-flag word, with bit i for data register i. 7 is the read-flag word, with bit i for data register i, and bit 7 is the software reset bit. 8 is the mask word, with write masks in bits 5:0 and read masks in bits 13:8. The host sees the same 0–7 layout as 8-bit values. The host cannot reach the mask word.

Top module: `hmbx_port`

## Requirements
- R1: After reset, every data register, flag, mask and output is zero: h_ack, h_doe, irq_host_wr, irq_host_rd and soft_rst are all low.
- R2: A host write to address i (0–5) loads data register i with the 16-bit value {8'h00, byte} and sets bit i of the write-flag word (core address 6).
- R3: A host read of address i (0–5) drives the low byte of data register i on h_dout with h_doe high. When the strobe is released, bit i of the read-flag word (core address 7) is set. A host read of address 6 returns the write flags in bits 5:0.
- R4: irq_host_wr is high exactly when some write flag i and write mask bit i (core address 8, bit i) are both set and en_host_wr is high. irq_host_rd follows the same rule with the read flags, the read mask bits (core address 8, bit 8+i) and en_host_rd.
- R5: A core read or write of data register i clears both of its flags. A core write of a data register becomes visible to later host reads.
- R6: With strap_combined=0, h_rd_n and h_wr_n are separate active-low strobes. With strap_combined=1, h_rd_n is a read/write select (1 = read) and h_wr_n is an active-low data strobe.
- R7: With strap_mux=1, the access address is bits 2:0 of h_din, captured while h_ale is high. With strap_mux=0, the address comes from h_addr.
- R8: Writing a 1 to bit 7 of address 7, from either side, drives soft_rst high for exactly 5 clock cycles, and bit 7 reads as 1 during that pulse. A further set while the pulse is running does not lengthen it.
- R9: h_ack rises after an access is accepted and stays high until the strobe is released. Strobes given while h_cs_n is high cause no access and no acknowledge, and leave the registers unchanged.
- R10: Host writes to address 6, and host writes to address 7 with bit 7 clear, change neither the flags nor soft_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_combined | input | 1 | 0: separate read/write strobes, 1: read/write select plus data strobe |
| strap_mux | input | 1 | 0: address pins, 1: address multiplexed on data pins |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Read strobe, or read/write select in combined mode |
| h_wr_n | input | 1 | Write strobe, or data strobe in combined mode |
| h_ale | input | 1 | Address latch enable for multiplexed mode |
| h_addr | input | 3 | Host register address (non-multiplexed mode) |
| h_din | input | 8 | Host data in (and address in multiplexed mode) |
| h_dout | output | 8 | Host read data |
| h_doe | output | 1 | Output enable for h_dout during a host read |
| h_ack | output | 1 | Host access acknowledge |
| c_sel | input | 1 | Core bus select |
| c_we | input | 1 | Core bus write enable |
| c_addr | input | 4 | Core register address |
| c_wdata | input | 16 | Core write data |
| c_rdata | output | 16 | Core read data (combinational) |
| en_host_wr | input | 1 | Global enable for the write interrupt |
| en_host_rd | input | 1 | Global enable for the read interrupt |
| irq_host_wr | output | 1 | Masked host-write interrupt |
| irq_host_rd | output | 1 | Masked host-read interrupt |
| soft_rst | output | 1 | Software reset pulse |

## Verification
A wrong synchronizer state or a wrong strobe decode shows up within a few core cycles. The acknowledge stays low, or a flag bit appears on the wrong register in the status words. A stuck or misrouted flag shows on an interrupt line in the cycle after the access that should have changed it, and a core read of the status words exposes it at once. An off-by-one in the reset timer changes the count of soft_rst cycles, which the bench measures per trigger. The sweep visits every data register under all four strap combinations, so a wrong address path in any bus style lands data or flags in a register the bench reads back.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    // indices of the host control pins inside the synchronizer bank
    localparam int unsigned PIN_CS  = 0;
    localparam int unsigned PIN_RD  = 1;
    localparam int unsigned PIN_WR  = 2;
    localparam int unsigned PIN_ALE = 3;
    localparam int unsigned NPIN    = 4;

    // idle level of each pin: selects and strobes high, latch enable low
    localparam logic [NPIN-1:0] PIN_IDLE = 4'b0111;

    // host access events seen in the core clock domain
    typedef struct packed {
        logic wr_evt;    // write strobe edge accepted
        logic rd_start;  // read strobe edge accepted
        logic rd_done;   // read strobe released
        logic rd_act;    // read in progress
        logic wr_act;    // write in progress
    } hev_t;

endpackage

// File: rtl/hmbx_host_sync.sv
module hmbx_host_sync
    import hmbx_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter int unsigned AW     = 3,
    parameter int unsigned BW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_combined,
    input  logic          strap_mux,
    input  logic          h_cs_n,
    input  logic          h_rd_n,
    input  logic          h_wr_n,
    input  logic          h_ale,
    input  logic [AW-1:0] h_addr,
    input  logic [BW-1:0] h_din,
    output hev_t          ev,
    output logic [AW-1:0] acc_addr
);

    typedef struct packed {
        logic [NPIN-1:0][STAGES-1:0] chain;
        logic                        rd;
        logic                        wr;
        logic [AW-1:0]               addr;
    } sync_st_t;

    sync_st_t st_d, st_q;

    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] s;
    logic            sel, rd_now, wr_now;

    assign pins = {h_ale, h_wr_n, h_rd_n, h_cs_n};

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NPIN; k++) begin
            st_d.chain[k] = {st_q.chain[k][STAGES-2:0], pins[k]};
            s[k]          = st_q.chain[k][STAGES-1];
        end

        sel = !s[PIN_CS];
        if (strap_combined) begin
            rd_now = sel && !s[PIN_WR] &&  s[PIN_RD];
            wr_now = sel && !s[PIN_WR] && !s[PIN_RD];
        end else begin
            rd_now = sel && !s[PIN_RD];
            wr_now = sel && !s[PIN_WR];
        end
        st_d.rd = rd_now;
        st_d.wr = wr_now;

        ev.wr_evt   = wr_now && !st_q.wr;
        ev.rd_start = rd_now && !st_q.rd;
        ev.rd_done  = !rd_now && st_q.rd;
        ev.rd_act   = st_q.rd;
        ev.wr_act   = st_q.wr;

        acc_addr = st_q.addr;
        if (strap_mux) begin
            if (s[PIN_ALE]) st_d.addr = h_din[AW-1:0];
        end else if (ev.wr_evt || ev.rd_start) begin
            st_d.addr = h_addr;
            acc_addr  = h_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NPIN; k++) st_q.chain[k] <= {STAGES{PIN_IDLE[k]}};
            st_q.rd   <= 1'b0;
            st_q.wr   <= 1'b0;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a read edge never follows a cycle with the read already active
    a_r6_rd_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rd_start |=> !ev.rd_start);

endmodule

// File: rtl/hmbx_rst_pulse.sv
module hmbx_rst_pulse #(
    parameter int unsigned LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);

    localparam int unsigned CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rp_st_t;

    rp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
        else if (trig)       st_d.cnt = CW'(LEN);
    end

    assign pulse = (st_q.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // checker-side run-length counter for the pulse
    logic [CW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_q <= '0;
        else if (pulse) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> (run_q == (CW+1)'(LEN)));

    a_r8_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CW+1)'(LEN));

endmodule

// File: rtl/hmbx_port.sv
module hmbx_port
    import hmbx_pkg::*;
#(
    parameter int unsigned N_MBX       = 6,
    parameter int unsigned DW          = 16,
    parameter int unsigned HBW         = 8,
    parameter int unsigned HAW         = 3,
    parameter int unsigned CAW         = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RST_LEN     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_combined,
    input  logic           strap_mux,
    input  logic           h_cs_n,
    input  logic           h_rd_n,
    input  logic           h_wr_n,
    input  logic           h_ale,
    input  logic [HAW-1:0] h_addr,
    input  logic [HBW-1:0] h_din,
    output logic [HBW-1:0] h_dout,
    output logic           h_doe,
    output logic           h_ack,
    input  logic           c_sel,
    input  logic           c_we,
    input  logic [CAW-1:0] c_addr,
    input  logic [DW-1:0]  c_wdata,
    output logic [DW-1:0]  c_rdata,
    input  logic           en_host_wr,
    input  logic           en_host_rd,
    output logic           irq_host_wr,
    output logic           irq_host_rd,
    output logic           soft_rst
);

    localparam int unsigned ADDR_WFLAG = N_MBX;
    localparam int unsigned ADDR_RFLAG = N_MBX + 1;
    localparam int unsigned ADDR_MASK  = N_MBX + 2;
    localparam int unsigned SRST_BIT   = HBW - 1;
    localparam int unsigned RMASK_LSB  = HBW;

    typedef struct packed {
        logic [N_MBX-1:0][DW-1:0] data;
        logic [N_MBX-1:0]         wflag;
        logic [N_MBX-1:0]         rflag;
        logic [N_MBX-1:0]         wmask;
        logic [N_MBX-1:0]         rmask;
    } mbx_st_t;

    mbx_st_t st_d, st_q;

    hev_t           ev;
    logic [HAW-1:0] acc_addr;
    logic [N_MBX-1:0] core_oh;
    logic [N_MBX-1:0] host_oh;
    logic           core_wr;
    logic           srst_trig;

    hmbx_host_sync #(
        .STAGES (SYNC_STAGES),
        .AW     (HAW),
        .BW     (HBW)
    ) sync_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_combined (strap_combined),
        .strap_mux      (strap_mux),
        .h_cs_n         (h_cs_n),
        .h_rd_n         (h_rd_n),
        .h_wr_n         (h_wr_n),
        .h_ale          (h_ale),
        .h_addr         (h_addr),
        .h_din          (h_din),
        .ev             (ev),
        .acc_addr       (acc_addr)
    );

    hmbx_rst_pulse #(
        .LEN (RST_LEN)
    ) rst_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (srst_trig),
        .pulse (soft_rst)
    );

    // next-state: core access first, host access last so host updates win
    always_comb begin
        st_d    = st_q;
        core_wr = c_sel && c_we;

        for (int i = 0; i < N_MBX; i++) begin
            core_oh[i] = c_sel && (c_addr == CAW'(i));
            host_oh[i] = (acc_addr == HAW'(i));
        end

        for (int i = 0; i < N_MBX; i++) begin
            if (core_oh[i]) begin
                st_d.wflag[i] = 1'b0;
                st_d.rflag[i] = 1'b0;
                if (c_we) st_d.data[i] = c_wdata;
            end
        end

        if (core_wr && (c_addr == CAW'(ADDR_MASK))) begin
            st_d.wmask = c_wdata[N_MBX-1:0];
            st_d.rmask = c_wdata[RMASK_LSB +: N_MBX];
        end

        for (int i = 0; i < N_MBX; i++) begin
            if (ev.wr_evt && host_oh[i]) begin
                st_d.data[i]  = DW'(h_din);
                st_d.wflag[i] = 1'b1;
            end
            if (ev.rd_done && host_oh[i]) st_d.rflag[i] = 1'b1;
        end

        srst_trig = (ev.wr_evt && (acc_addr == HAW'(ADDR_RFLAG)) && h_din[SRST_BIT])
                 || (core_wr && (c_addr == CAW'(ADDR_RFLAG)) && c_wdata[SRST_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // host read path
    always_comb begin
        h_dout = '0;
        for (int i = 0; i < N_MBX; i++)
            if (acc_addr == HAW'(i)) h_dout = st_q.data[i][HBW-1:0];
        if (acc_addr == HAW'(ADDR_WFLAG)) h_dout = HBW'(st_q.wflag);
        if (acc_addr == HAW'(ADDR_RFLAG)) begin
            h_dout           = HBW'(st_q.rflag);
            h_dout[SRST_BIT] = soft_rst;
        end
    end

    assign h_doe = ev.rd_act;
    assign h_ack = ev.rd_act | ev.wr_act;

    // core read path
    always_comb begin
        c_rdata = '0;
        for (int i = 0; i < N_MBX; i++)
            if (c_addr == CAW'(i)) c_rdata = st_q.data[i];
        if (c_addr == CAW'(ADDR_WFLAG)) c_rdata = DW'(st_q.wflag);
        if (c_addr == CAW'(ADDR_RFLAG)) begin
            c_rdata           = DW'(st_q.rflag);
            c_rdata[SRST_BIT] = soft_rst;
        end
        if (c_addr == CAW'(ADDR_MASK)) begin
            c_rdata[N_MBX-1:0]         = st_q.wmask;
            c_rdata[RMASK_LSB +: N_MBX] = st_q.rmask;
        end
    end

    assign irq_host_wr = en_host_wr && |(st_q.wflag & st_q.wmask);
    assign irq_host_rd = en_host_rd && |(st_q.rflag & st_q.rmask);

    // R2: a write flag only appears after an accepted host write
    a_r2_wflag_source: assert property (@(posedge clk) disable iff (!rst_n)
        |(st_q.wflag & ~$past(st_q.wflag)) |-> $past(ev.wr_evt));

    // R3: a read flag only appears after a host read is released
    a_r3_rflag_source: assert property (@(posedge clk) disable iff (!rst_n)
        |(st_q.rflag & ~$past(st_q.rflag)) |-> $past(ev.rd_done));

    // R5: a core access to a data register leaves its flags clear
    a_r5_core_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|core_oh) && !ev.wr_evt && !ev.rd_done
        |=> ((st_q.wflag | st_q.rflag) & $past(core_oh)) == '0);

    // R4: the write interrupt never rises while globally disabled
    a_r4_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_host_wr) |-> en_host_wr);

    // R9: the acknowledge rises only after an accepted strobe edge
    a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_ack) |-> $past(ev.wr_evt || ev.rd_start));

endmodule

// File: tb/hmbx_port_tb.sv
module hmbx_port_tb_top;

    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_combined = 1'b0;
    logic        strap_mux = 1'b0;
    logic        h_cs_n = 1'b1;
    logic        h_rd_n = 1'b1;
    logic        h_wr_n = 1'b1;
    logic        h_ale = 1'b0;
    logic [2:0]  h_addr = '0;
    logic [7:0]  h_din = '0;
    logic [7:0]  h_dout;
    logic        h_doe;
    logic        h_ack;
    logic        c_sel = 1'b0;
    logic        c_we = 1'b0;
    logic [3:0]  c_addr = '0;
    logic [15:0] c_wdata = '0;
    logic [15:0] c_rdata;
    logic        en_host_wr = 1'b0;
    logic        en_host_rd = 1'b0;
    logic        irq_host_wr;
    logic        irq_host_rd;
    logic        soft_rst;

    int n_chk  = 0;
    int n_fail = 0;
    int srst_cycles = 0;

    always #(CLK_NS/2) clk = ~clk;

    hmbx_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .strap_combined(strap_combined), .strap_mux(strap_mux),
        .h_cs_n(h_cs_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_ale(h_ale),
        .h_addr(h_addr), .h_din(h_din), .h_dout(h_dout), .h_doe(h_doe), .h_ack(h_ack),
        .c_sel(c_sel), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .en_host_wr(en_host_wr), .en_host_rd(en_host_rd),
        .irq_host_wr(irq_host_wr), .irq_host_rd(irq_host_rd), .soft_rst(soft_rst)
    );

    always @(negedge clk) if (soft_rst) srst_cycles++;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic core_read(input logic [3:0] a, output logic [15:0] d);
        c_sel = 1'b1; c_we = 1'b0; c_addr = a;
        #1 d = c_rdata;
        @(posedge clk);
        @(negedge clk);
        c_sel = 1'b0;
    endtask

    task automatic core_write(input logic [3:0] a, input logic [15:0] d);
        c_sel = 1'b1; c_we = 1'b1; c_addr = a; c_wdata = d;
        @(posedge clk);
        @(negedge clk);
        c_sel = 1'b0; c_we = 1'b0;
    endtask

    // one host access in the current strap style; cs_en=0 keeps the chip deselected
    task automatic host_acc(input bit is_wr, input logic [2:0] a, input logic [7:0] d,
                            input bit cs_en, output logic [7:0] rd);
        if (strap_mux) begin
            h_din = 8'(a); h_ale = 1'b1;
            wait_clk(4);
            h_ale = 1'b0;
            wait_clk(2);
        end else begin
            h_addr = a;
        end
        if (is_wr) h_din = d;
        h_cs_n = !cs_en;
        if (strap_combined) h_rd_n = !is_wr;
        wait_clk(1);
        if (strap_combined)  h_wr_n = 1'b0;
        else if (is_wr)      h_wr_n = 1'b0;
        else                 h_rd_n = 1'b0;
        wait_clk(6);
        chk("R9 ack during access", 32'(h_ack), 32'(cs_en));
        rd = h_dout;
        if (!is_wr && cs_en) chk("R3 output enable", 32'(h_doe), 32'd1);
        h_wr_n = 1'b1;
        if (!strap_combined) h_rd_n = 1'b1;
        wait_clk(1);
        h_cs_n = 1'b1; h_rd_n = 1'b1;
        wait_clk(6);
        chk("R9 ack released", 32'(h_ack), 32'd0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  hr;
        int          s0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        chk("R1 irq wr", 32'(irq_host_wr), 0);
        chk("R1 irq rd", 32'(irq_host_rd), 0);
        chk("R1 ack", 32'(h_ack), 0);
        chk("R1 doe", 32'(h_doe), 0);
        chk("R1 soft reset", 32'(soft_rst), 0);
        for (int a = 0; a < 9; a++) begin
            core_read(4'(a), d);
            chk("R1 register zero", 32'(d), 0);
        end

        en_host_wr = 1'b1; en_host_rd = 1'b1;
        core_write(4'd8, 16'h3F3F);
        core_read(4'd8, d);
        chk("R4 mask readback", 32'(d), 32'h3F3F);

        // sweep every data register in every strap combination (R6, R7)
        for (int cfg = 0; cfg < 4; cfg++) begin
            strap_combined = cfg[0];
            strap_mux      = cfg[1];
            wait_clk(3);
            for (int i = 0; i < 6; i++) begin
                logic [7:0]  v;
                logic [15:0] w;
                v = 8'((i * 29 + cfg * 71 + 3) & 8'hFF);
                w = 16'hA500 | 16'(v ^ 8'h5A);
                host_acc(1'b1, 3'(i), v, 1'b1, hr);
                core_read(4'd6, d);
                chk("R2 R6 R7 write flag", 32'(d), 32'(1 << i));
                chk("R4 write irq", 32'(irq_host_wr), 1);
                core_read(4'(i), d);
                chk("R2 R6 R7 data upper zero", 32'(d), 32'({8'h00, v}));
                chk("R5 write irq cleared", 32'(irq_host_wr), 0);
                core_read(4'd6, d);
                chk("R5 write flag cleared", 32'(d), 0);
                core_write(4'(i), w);
                host_acc(1'b0, 3'(i), 8'h00, 1'b1, hr);
                chk("R3 R5 R6 R7 host read data", 32'(hr), 32'(w[7:0]));
                core_read(4'd7, d);
                chk("R3 read flag", 32'(d), 32'(1 << i));
                chk("R4 read irq", 32'(irq_host_rd), 1);
                core_write(4'(i), w);
                core_read(4'd7, d);
                chk("R5 read flag cleared", 32'(d), 0);
                chk("R5 read irq cleared", 32'(irq_host_rd), 0);
            end
        end

        strap_combined = 1'b0; strap_mux = 1'b0;
        wait_clk(3);

        // R3: host read of the write-flag word
        host_acc(1'b1, 3'd2, 8'h77, 1'b1, hr);
        host_acc(1'b0, 3'd6, 8'h00, 1'b1, hr);
        chk("R3 host status read", 32'(hr), 32'h04);

        // R4: gating by the global enable and the mask
        en_host_wr = 1'b0;
        wait_clk(1);
        chk("R4 irq off when disabled", 32'(irq_host_wr), 0);
        en_host_wr = 1'b1;
        core_write(4'd8, 16'h3F3B);
        chk("R4 irq off when masked", 32'(irq_host_wr), 0);
        core_write(4'd8, 16'h3F3F);
        chk("R4 irq on when unmasked", 32'(irq_host_wr), 1);
        core_read(4'd2, d);
        core_read(4'd6, d);
        chk("R5 status after clear", 32'(d), 0);

        // R9: deselected strobes have no effect
        core_write(4'd4, 16'h1234);
        host_acc(1'b1, 3'd4, 8'hEE, 1'b0, hr);
        core_read(4'd6, d);
        chk("R9 no flag when deselected", 32'(d), 0);
        core_read(4'd4, d);
        chk("R9 data kept when deselected", 32'(d), 32'h1234);

        // R10: host writes to status words with the reset bit clear
        s0 = srst_cycles;
        host_acc(1'b1, 3'd6, 8'hFF, 1'b1, hr);
        host_acc(1'b1, 3'd7, 8'h3F, 1'b1, hr);
        core_read(4'd6, d);
        chk("R10 write flags unchanged", 32'(d), 0);
        core_read(4'd7, d);
        chk("R10 read flags unchanged", 32'(d), 0);
        chk("R10 no reset pulse", 32'(srst_cycles - s0), 0);

        // R8: software reset from the core side
        s0 = srst_cycles;
        core_write(4'd7, 16'h0080);
        core_read(4'd7, d);
        chk("R8 bit reads set during pulse", 32'(d), 32'h0080);
        wait_clk(10);
        chk("R8 core pulse length", 32'(srst_cycles - s0), 5);
        core_read(4'd7, d);
        chk("R8 bit clear after pulse", 32'(d), 0);

        // R8: set twice in a row does not lengthen the pulse
        s0 = srst_cycles;
        core_write(4'd7, 16'h0080);
        core_write(4'd7, 16'h0080);
        wait_clk(10);
        chk("R8 no extension", 32'(srst_cycles - s0), 5);

        // R8: software reset from the host side
        s0 = srst_cycles;
        host_acc(1'b1, 3'd7, 8'h80, 1'b1, hr);
        wait_clk(4);
        chk("R8 host pulse length", 32'(srst_cycles - s0), 5);

        report();
    end

endmodule